// File: doc/BRIEF.md
# High-Region Windowed Memory Address Decoder

This block decides which host memory addresses a bridge forwards downstream. The topmost 256MB of the 32-bit host address space, beginning at 0xF0000000, is divided into 32 fixed slices of 8MB each. A 32-bit window-enable register, written over a simple register bus, holds one bit per slice. Each host address that comes with a valid strobe and a memory-space qualifier is compared against this bitmap. When the address falls inside an enabled slice, the block raises a claim flag and reports which slice matched.

The enable register holds zero after reset, so nothing is claimed until software opens one or more slices. Setting neighbouring bits merges their slices into one unbroken decoded range. I/O-space cycles are never claimed, and neither are addresses below the high region. Claim and index are both registered and appear one clock after the address is presented.

Top module: `hiwin_decoder`

## Requirements
- R1: While reset is high, and in the first cycle after it, win_claim is 0 and win_idx is 0. Reset clears the enable register to zero.
- R2: A cfg_wr pulse with cfg_addr equal to 0x060 loads cfg_wdata into the enable register, where bit i controls slice i. A write to any other cfg_addr leaves the enable register unchanged.
- R3: Suppose an address is presented in cycle k with hst_valid=1 and hst_is_mem=1, its bits 31:28 equal 0xF, and the enable bit chosen by its bits 27:23 is set. Then in cycle k+1 win_claim is 1 and win_idx equals bits 27:23.
- R4: An address whose bits 31:28 are not 0xF is never claimed, even when every enable bit is set.
- R5: A cycle with hst_is_mem=0 (I/O space) is never claimed.
- R6: With the enable register at zero, no address is claimed.
- R7: Adjacent enabled slices form one contiguous range. The last byte of slice i and the first byte of slice i+1 are both claimed, each with its own index.
- R8: When win_claim is 0, win_idx is 0. A cycle with hst_valid=0 produces no claim.
- R9: The enable value seen by an address is the value held before the clock edge. A write in the same cycle as an address takes effect only for addresses presented in later cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_wr | input | 1 | Register write strobe |
| cfg_addr | input | 12 | Register byte offset |
| cfg_wdata | input | 32 | Register write data |
| hst_valid | input | 1 | Host address valid |
| hst_is_mem | input | 1 | 1 = memory cycle, 0 = I/O cycle |
| hst_addr | input | 32 | Host address |
| win_claim | output | 1 | Address claimed (registered) |
| win_idx | output | 5 | Index of the matching slice, 0 when not claimed |

## Verification
The bench tests the slice boundaries with the last and first byte on each side of a seam between two enabled slices. A decoder that dropped or shifted an index bit would claim the wrong neighbour, or leave a gap in the merged range. The bench also probes slice 31 at 0xFFFFFFFF, addresses just under 0xF0000000, and low addresses whose bits 27:23 select an enabled slice. A tag comparison that was too loose would claim those low addresses. It also sends I/O cycles and writes to offsets near the enable register, which a design that ignores the qualifier or decodes the offset only partly would act on. Finally, it places a write in the same cycle as an address to catch a design that bypasses the new enable value into the current decode.

// File: rtl/hiwin_pkg.sv
package hiwin_pkg;
  // Qualifier carried alongside every host address
  typedef struct packed {
    logic valid;
    logic is_mem;
  } hst_qual_t;
endpackage

// File: rtl/hiwin_enable_reg.sv
module hiwin_enable_reg #(
  parameter int REG_AW = 12,
  parameter int NUM_WIN = 32,
  parameter logic [REG_AW-1:0] EN_OFFSET = 12'h060
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               cfg_wr,
  input  logic [REG_AW-1:0]  cfg_addr,
  input  logic [NUM_WIN-1:0] cfg_wdata,
  output logic [NUM_WIN-1:0] en_map
);
  logic hit_offset;
  assign hit_offset = cfg_wr && (cfg_addr == EN_OFFSET);

  always_ff @(posedge clk) begin
    if (rst)             en_map <= '0;
    else if (hit_offset) en_map <= cfg_wdata;
  end
endmodule

// File: rtl/hiwin_match.sv
module hiwin_match
  import hiwin_pkg::*;
#(
  parameter int NUM_WIN = 32,
  parameter int IDX_W = 5,
  parameter int TAG_W = 4,
  parameter logic [TAG_W-1:0] REGION_TAG = 4'hF
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [NUM_WIN-1:0] en_map,
  input  hst_qual_t          qual,
  input  logic [TAG_W-1:0]   addr_tag,
  input  logic [IDX_W-1:0]   addr_idx,
  output logic               claim_q,
  output logic [IDX_W-1:0]   idx_q
);
  logic               in_region;
  logic [NUM_WIN-1:0] slot_hit;
  logic               any_hit;

  assign in_region = qual.valid && qual.is_mem && (addr_tag == REGION_TAG);

  // One comparator per slice; at most one can fire
  for (genvar w = 0; w < NUM_WIN; w++) begin : g_slot
    assign slot_hit[w] = in_region && en_map[w] && (addr_idx == IDX_W'(w));
  end

  assign any_hit = |slot_hit;

  always_ff @(posedge clk) begin
    if (rst) begin
      claim_q <= 1'b0;
      idx_q   <= '0;
    end else begin
      claim_q <= any_hit;
      idx_q   <= any_hit ? addr_idx : '0;
    end
  end
endmodule

// File: rtl/hiwin_decoder.sv
module hiwin_decoder
  import hiwin_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int REG_AW = 12,
  parameter int NUM_WIN = 32,
  parameter int WIN_SHIFT = 23,
  parameter logic [ADDR_W-1:0] REGION_BASE = 32'hF000_0000,
  parameter logic [REG_AW-1:0] EN_OFFSET = 12'h060
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic                       cfg_wr,
  input  logic [REG_AW-1:0]          cfg_addr,
  input  logic [NUM_WIN-1:0]         cfg_wdata,
  input  logic                       hst_valid,
  input  logic                       hst_is_mem,
  input  logic [ADDR_W-1:0]          hst_addr,
  output logic                       win_claim,
  output logic [$clog2(NUM_WIN)-1:0] win_idx
);
  localparam int IDX_W = $clog2(NUM_WIN);
  localparam int TAG_W = ADDR_W - WIN_SHIFT - IDX_W;
  localparam logic [TAG_W-1:0] REGION_TAG = REGION_BASE[ADDR_W-1 -: TAG_W];

  logic [NUM_WIN-1:0] en_map;
  hst_qual_t          qual;
  logic               unused_low;

  assign qual.valid  = hst_valid;
  assign qual.is_mem = hst_is_mem;
  assign unused_low  = ^hst_addr[WIN_SHIFT-1:0];

  hiwin_enable_reg #(
    .REG_AW(REG_AW), .NUM_WIN(NUM_WIN), .EN_OFFSET(EN_OFFSET)
  ) u_en (
    .clk(clk), .rst(rst), .cfg_wr(cfg_wr), .cfg_addr(cfg_addr),
    .cfg_wdata(cfg_wdata), .en_map(en_map)
  );

  hiwin_match #(
    .NUM_WIN(NUM_WIN), .IDX_W(IDX_W), .TAG_W(TAG_W), .REGION_TAG(REGION_TAG)
  ) u_match (
    .clk(clk), .rst(rst), .en_map(en_map), .qual(qual),
    .addr_tag(hst_addr[ADDR_W-1 -: TAG_W]),
    .addr_idx(hst_addr[WIN_SHIFT +: IDX_W]),
    .claim_q(win_claim), .idx_q(win_idx)
  );
endmodule

// File: rtl/hiwin_decoder_chk.sv
module hiwin_decoder_chk #(
  parameter int ADDR_W = 32,
  parameter int IDX_W = 5,
  parameter int WIN_SHIFT = 23,
  parameter logic [ADDR_W-1:0] REGION_BASE = 32'hF000_0000
) (
  input logic              clk,
  input logic              rst,
  input logic              hst_valid,
  input logic              hst_is_mem,
  input logic [ADDR_W-1:0] hst_addr,
  input logic              win_claim,
  input logic [IDX_W-1:0]  win_idx
);
  localparam int TAG_W = ADDR_W - WIN_SHIFT - IDX_W;

  AST_RESET_QUIET: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (!win_claim && win_idx == '0)); // R1

  AST_CLAIM_INDEX: assert property (@(posedge clk) disable iff (rst)
    win_claim |-> (win_idx == $past(hst_addr[WIN_SHIFT +: IDX_W]))); // R3

  AST_OUTSIDE_REGION: assert property (@(posedge clk) disable iff (rst)
    (hst_valid && hst_addr[ADDR_W-1 -: TAG_W] != REGION_BASE[ADDR_W-1 -: TAG_W])
      |=> !win_claim); // R4

  AST_IO_NEVER: assert property (@(posedge clk) disable iff (rst)
    (hst_valid && !hst_is_mem) |=> !win_claim); // R5

  AST_IDLE_IDX_ZERO: assert property (@(posedge clk) disable iff (rst)
    !win_claim |-> (win_idx == '0)); // R8

  AST_NO_VALID: assert property (@(posedge clk) disable iff (rst)
    !hst_valid |=> !win_claim); // R8
endmodule

bind hiwin_decoder hiwin_decoder_chk #(
  .ADDR_W(ADDR_W), .IDX_W($clog2(NUM_WIN)), .WIN_SHIFT(WIN_SHIFT),
  .REGION_BASE(REGION_BASE)
) u_chk (
  .clk(clk), .rst(rst), .hst_valid(hst_valid), .hst_is_mem(hst_is_mem),
  .hst_addr(hst_addr), .win_claim(win_claim), .win_idx(win_idx)
);

// File: tb/sim_hiwin_decoder.sv
`timescale 1ns/1ps
module sim_hiwin_decoder;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        cfg_wr = 1'b0;
  logic [11:0] cfg_addr = '0;
  logic [31:0] cfg_wdata = '0;
  logic        hst_valid = 1'b0;
  logic        hst_is_mem = 1'b0;
  logic [31:0] hst_addr = '0;
  logic        win_claim;
  logic [4:0]  win_idx;

  int checks = 0;
  int errors = 0;
  bit started = 0;
  bit done = 0;

  string cur_req = "R1";
  string exp_req = "R1";
  bit [31:0] m_en = '0;
  bit        exp_claim = 0;
  int        exp_idx = 0;

  always #5 clk = ~clk;

  hiwin_decoder u0 (
    .clk(clk), .rst(rst), .cfg_wr(cfg_wr), .cfg_addr(cfg_addr),
    .cfg_wdata(cfg_wdata), .hst_valid(hst_valid), .hst_is_mem(hst_is_mem),
    .hst_addr(hst_addr), .win_claim(win_claim), .win_idx(win_idx)
  );

  // Behavioural reference: region membership by arithmetic range test
  always @(posedge clk) begin
    longint unsigned a;
    int slice;
    bit hit;
    started <= 1;
    exp_req <= cur_req;
    if (rst) begin
      m_en <= '0;
      exp_claim <= 0;
      exp_idx <= 0;
    end else begin
      a = longint'(hst_addr);
      slice = (a >= 64'hF000_0000) ? int'((a - 64'hF000_0000) / 64'h80_0000) : -1;
      hit = hst_valid && hst_is_mem && slice >= 0 && m_en[slice];
      exp_claim <= hit;
      exp_idx <= hit ? slice : 0;
      if (cfg_wr && cfg_addr == 12'h060) m_en <= cfg_wdata;
    end
  end

  always @(negedge clk) begin
    if (started && !done) begin
      checks++;
      if (win_claim !== exp_claim || int'(win_idx) !== exp_idx) begin
        errors++;
        $display("FAIL %s: claim=%0b idx=%0d expected claim=%0b idx=%0d",
                 exp_req, win_claim, win_idx, exp_claim, exp_idx);
      end
    end
  end

  task automatic cyc(input string req, input bit wr, input logic [11:0] wa,
                     input logic [31:0] wd, input bit v, input bit mem,
                     input logic [31:0] a);
    @(negedge clk);
    cur_req = req;
    cfg_wr = wr; cfg_addr = wa; cfg_wdata = wd;
    hst_valid = v; hst_is_mem = mem; hst_addr = a;
  endtask

  task automatic wr_en(input string req, input logic [11:0] wa, input logic [31:0] wd);
    cyc(req, 1, wa, wd, 0, 0, 32'h0);
  endtask

  task automatic probe(input string req, input logic [31:0] a);
    cyc(req, 0, 12'h0, 32'h0, 1, 1, a);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    cur_req = "R1";
    rst = 1'b0;
    probe("R1", 32'hF000_0000);           // enable cleared by reset
    probe("R6", 32'hF7FF_FFFF);
    probe("R6", 32'hFFFF_FFFF);
    wr_en("R2", 12'h064, 32'hFFFF_FFFF);  // wrong offset: ignored
    wr_en("R2", 12'h020, 32'hFFFF_FFFF);
    probe("R2", 32'hF080_0000);
    probe("R2", 32'hF000_0000);
    wr_en("R2", 12'h060, 32'h0000_0018);  // slices 3 and 4
    probe("R7", 32'hF17F_FFFF);           // slice 2 end: off
    probe("R7", 32'hF180_0000);           // slice 3 start
    probe("R7", 32'hF1FF_FFFF);           // slice 3 end
    probe("R7", 32'hF200_0000);           // slice 4 start
    probe("R7", 32'hF27F_FFFF);           // slice 4 end
    probe("R7", 32'hF280_0000);           // slice 5: off
    wr_en("R3", 12'h060, 32'h8000_0001);
    probe("R3", 32'hF000_0000);
    probe("R3", 32'hFFFF_FFFF);
    probe("R3", 32'hF800_0000);
    wr_en("R4", 12'h060, 32'hFFFF_FFFF);
    probe("R4", 32'hEFFF_FFFF);
    probe("R4", 32'h0000_0000);
    probe("R4", 32'h7F80_0000);
    probe("R4", 32'hE180_0000);
    probe("R3", 32'hF000_0000);
    cyc("R5", 0, 12'h0, 32'h0, 1, 0, 32'hF100_0000);
    cyc("R5", 0, 12'h0, 32'h0, 1, 0, 32'hFFFF_FFFF);
    cyc("R8", 0, 12'h0, 32'h0, 0, 1, 32'hF100_0000);
    probe("R3", 32'hF100_0000);
    cyc("R9", 1, 12'h060, 32'h0, 1, 1, 32'hF000_0000); // old enable applies
    probe("R9", 32'hF000_0000);                          // now closed
    cyc("R9", 1, 12'h060, 32'h4, 1, 1, 32'hF100_0000);   // old value 0
    probe("R9", 32'hF100_0000);
    wr_en("R3", 12'h060, 32'h5555_5555);
    for (int i = 0; i < 32; i++)
      probe("R3", 32'hF000_0000 + (i << 23) + i * 1234);
    cyc("R8", 0, 12'h0, 32'h0, 0, 0, 32'h0);
    rst = 1'b1;
    cyc("R1", 0, 12'h0, 32'h0, 1, 1, 32'hF000_0000);
    cyc("R1", 0, 12'h0, 32'h0, 0, 0, 32'h0);
    rst = 1'b0;
    probe("R1", 32'hF000_0000);
    probe("R6", 32'hF800_0000);
    @(negedge clk);
    @(negedge clk);
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #100000;
    if (!done) begin
      done = 1;
      checks++;
      errors++;
      $display("FAIL watchdog: run did not finish, actual=hung expected=done");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule